// File: doc/BRIEF.md
# Clock Divider Transition Sequencer

This block moves a core clock from its current divide ratio to a new one chosen from 1, 2, 4, 6 and 8. While it does so, it keeps the memory refresh interval and the memory self-refresh enable consistent with the clock. A request strobe carries a target index. The sequencer then runs a fixed series of output updates: the divider mode field, the refresh count field and the self-refresh enable. Between updates it inserts waits for the clock generator to settle and for outstanding refresh counts to run out. When the whole series is complete it raises a one-cycle done pulse.

The order of the updates depends on the direction of the change. The refresh count is a function of the base clock frequency and the divide ratio. A parameter selects how that count is produced: a precomputed table indexed by ratio, or an iterative divider that works it out from the frequency on each step. A jump between divide-by-1 and any ratio above 2 is split into two steps, with divide-by-2 in between.

Top module: `clkdiv_seq`

## Requirements
- R1: Target index 0, 1, 2, 3 and 4 selects ratio 1, 2, 4, 6 and 8. The 3-bit `div_mode` output encodes these ratios as 000, 001, 011, 010 and 100 respectively, and never shows any other value.
- R2: After a transition completes, `refresh_cnt` equals floor(BASE_CLK_HZ × 7800 / (64 × ratio × 10^9)) for the new ratio.
- R3: When the clock speeds up to ratio 1, `sref_en` is cleared first, then `div_mode` is written, then `refresh_cnt` is written.
- R4: When the clock slows from ratio 1 to ratio 2, `refresh_cnt` is written first, then `div_mode` is written, then `sref_en` is set. `sref_en` is low whenever the ratio is 1.
- R5: A change from ratio 1 to ratio 4, 6 or 8, or from one of those ratios to ratio 1, runs as two steps. The first step goes to ratio 2, so `div_mode` never moves directly between 000 and 011, 010 or 100.
- R6: Between ratios of 2 and above, slowing down writes `refresh_cnt` before `div_mode`, and speeding up writes `div_mode` before `refresh_cnt`.
- R7: After each `div_mode` write, at least LOCK_CYCLES clock cycles pass before the next output update or the done pulse.
- R8: When slowing down while `sref_en` is low, the `div_mode` write comes at least 64 × (new count + old count) × old ratio clock cycles after the `refresh_cnt` write.
- R9: A request for the ratio already in use produces `done` on the cycle after the request, leaves `busy` low and changes no output.
- R10: A request with an index of 5, 6 or 7 produces a one-cycle `err` on the next cycle. It changes no output and produces no `done`.
- R11: `busy` is high from the cycle after an accepted request until `done`. Requests made while `busy` is high are ignored. `done` lasts exactly one cycle.
- R12: After reset, `div_mode` is 000, `refresh_cnt` holds the ratio-1 count, and `sref_en`, `busy`, `done` and `err` are low.
- R13: The table variant and the iterative-divider variant produce the same outputs after every transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Transition request strobe |
| req_idx | input | 3 | Target ratio index (0..4 valid) |
| div_mode | output | 3 | Divider mode field |
| refresh_cnt | output | 7 | Memory refresh count field |
| sref_en | output | 1 | Memory self-refresh enable |
| busy | output | 1 | Transition in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for an out-of-range index |

## Verification
The refresh drain wait only happens when the clock slows down while self-refresh is off. Because self-refresh follows the ratio, the only step seen at the ports that triggers it is the move out of ratio 1, and that includes the first half of a split jump to ratio 4, 6 or 8. The stimulus therefore returns to ratio 1 often: through directed cases and through a seeded random walk over all five ratios. A second request is also issued in the middle of a long drain, so that the block's treatment of requests arriving while busy shows up in the recorded order of output changes.

// File: rtl/clkdiv_seq_pkg.sv
package clkdiv_seq_pkg;

   localparam int unsigned NUM_RATIOS = 5;
   localparam int unsigned IDX_W      = 3;
   localparam int unsigned MODE_W     = 3;
   localparam int unsigned RC_W       = 7;
   localparam longint unsigned RC_INTERVAL_NS = 64'd7800;
   localparam longint unsigned RC_DEN_UNIT    = 64'd64_000_000_000;

   typedef enum logic [3:0] {
      S_IDLE, S_CALC, S_SRCLR, S_CNT, S_DRAIN, S_DIV, S_LOCK, S_SRSET, S_NEXT
   } seq_state_e;

   function automatic logic [MODE_W-1:0] idx_to_mode(input logic [IDX_W-1:0] idx);
      case (idx)
         3'd0:    return 3'b000;
         3'd1:    return 3'b001;
         3'd2:    return 3'b011;
         3'd3:    return 3'b010;
         default: return 3'b100;
      endcase
   endfunction

   function automatic logic [3:0] idx_to_ratio(input logic [IDX_W-1:0] idx);
      case (idx)
         3'd0:    return 4'd1;
         3'd1:    return 4'd2;
         3'd2:    return 4'd4;
         3'd3:    return 4'd6;
         default: return 4'd8;
      endcase
   endfunction

   function automatic int unsigned rc_value(input longint unsigned hz,
                                            input int unsigned ratio);
      return int'((hz * RC_INTERVAL_NS) / (RC_DEN_UNIT * longint'(ratio)));
   endfunction

   // Next intermediate index: jumps between 1 and >2 go through index 1.
   function automatic logic [IDX_W-1:0] step_toward(input logic [IDX_W-1:0] cur,
                                                    input logic [IDX_W-1:0] tgt);
      if ((cur == 3'd0 && tgt >= 3'd2) || (cur >= 3'd2 && tgt == 3'd0))
         return 3'd1;
      return tgt;
   endfunction

endpackage

// File: rtl/clkdiv_wait_timer.sv
module clkdiv_wait_timer #(
   parameter int unsigned TW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] value,
   output logic          expired
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (load)             cnt_q <= value;
      else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   assert_timer_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/clkdiv_refresh_calc.sv
module clkdiv_refresh_calc
   import clkdiv_seq_pkg::*;
#(
   parameter longint unsigned BASE_HZ  = 64'd500_000_000,
   parameter bit              USE_ITER = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] idx,
   output logic             valid,
   output logic [RC_W-1:0]  count
);
   localparam longint unsigned NUM   = BASE_HZ * RC_INTERVAL_NS;
   localparam int unsigned     QW    = RC_W + 1;
   localparam int unsigned     BPW   = $clog2(QW);

   logic [RC_W-1:0] tab [NUM_RATIOS];
   for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_tab
      assign tab[g] = RC_W'(rc_value(BASE_HZ, int'(idx_to_ratio(IDX_W'(g)))));
   end

   if (!USE_ITER) begin : g_lut
      logic            v_q;
      logic [RC_W-1:0] c_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            c_q <= '0;
         end else begin
            v_q <= start;
            if (start) c_q <= tab[idx];
         end
      end
      assign valid = v_q;
      assign count = c_q;
   end else begin : g_iter
      logic [63:0]     rem_q, den_q;
      logic [QW-1:0]   q_q;
      logic [BPW-1:0]  bit_q;
      logic            run_q, v_q;
      logic [IDX_W-1:0] idx_q;
      logic [63:0]     shifted;

      assign shifted = den_q << bit_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            q_q   <= '0;
            bit_q <= '0;
            run_q <= 1'b0;
            v_q   <= 1'b0;
            idx_q <= '0;
         end else begin
            v_q <= 1'b0;
            if (start) begin
               rem_q <= NUM;
               den_q <= RC_DEN_UNIT * 64'(idx_to_ratio(idx));
               q_q   <= '0;
               bit_q <= BPW'(QW - 1);
               run_q <= 1'b1;
               idx_q <= idx;
            end else if (run_q) begin
               if (rem_q >= shifted) begin
                  rem_q        <= rem_q - shifted;
                  q_q[bit_q]   <= 1'b1;
               end
               if (bit_q == '0) begin
                  run_q <= 1'b0;
                  v_q   <= 1'b1;
               end else begin
                  bit_q <= bit_q - 1'b1;
               end
            end
         end
      end

      assign valid = v_q;
      assign count = q_q[RC_W-1:0];

      assert_iter_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
         v_q |-> (q_q[QW-1] == 1'b0 && q_q[RC_W-1:0] == tab[idx_q]));
   end
endmodule

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
   import clkdiv_seq_pkg::*;
#(
   parameter longint unsigned BASE_CLK_HZ  = 64'd500_000_000,
   parameter int unsigned     LOCK_CYCLES  = 16,
   parameter bit              USE_ITER_DIV = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic [2:0]       req_idx,
   output logic [2:0]       div_mode,
   output logic [6:0]       refresh_cnt,
   output logic             sref_en,
   output logic             busy,
   output logic             done,
   output logic             err
);
   localparam int unsigned RC_MAX    = (1 << RC_W) - 1;
   localparam int unsigned DRAIN_MAX = 64 * 2 * RC_MAX * 8;
   localparam int unsigned BIG       = (DRAIN_MAX > LOCK_CYCLES) ? DRAIN_MAX : LOCK_CYCLES;
   localparam int unsigned TW        = $clog2(BIG + 1);
   localparam logic [RC_W-1:0] RC_RESET = RC_W'(rc_value(BASE_CLK_HZ, 1));

   if (rc_value(BASE_CLK_HZ, 1) > RC_MAX) begin : g_chk_rate
      $error("BASE_CLK_HZ gives a refresh count wider than the field");
   end
   if (LOCK_CYCLES < 1) begin : g_chk_lock
      $error("LOCK_CYCLES must be at least 1");
   end

   seq_state_e        state;
   logic [IDX_W-1:0]  cur_idx, tgt_idx, stp_idx;
   logic              slow_q;
   logic [RC_W-1:0]   new_cnt;
   logic [MODE_W-1:0] mode_q;
   logic [RC_W-1:0]   rc_q;
   logic              sref_q, done_q, err_q;

   logic              accept, calc_start, calc_valid;
   logic [IDX_W-1:0]  calc_idx;
   logic [RC_W-1:0]   calc_count;
   logic              tmr_load, tmr_expired;
   logic [TW-1:0]     tmr_val, drain_val;

   assign accept = (state == S_IDLE) && req && (req_idx < IDX_W'(NUM_RATIOS))
                   && (req_idx != cur_idx);

   always_comb begin
      calc_start = accept || (state == S_NEXT && stp_idx != tgt_idx);
      calc_idx   = (state == S_IDLE) ? step_toward(cur_idx, req_idx)
                                     : step_toward(stp_idx, tgt_idx);
      drain_val  = TW'(((32'(new_cnt) + 32'(rc_q)) * 32'(idx_to_ratio(cur_idx))) << 6);
      tmr_load   = (state == S_DIV) || (state == S_CNT && slow_q && !sref_q);
      tmr_val    = (state == S_DIV) ? TW'(LOCK_CYCLES) : drain_val;
   end

   clkdiv_refresh_calc #(
      .BASE_HZ  (BASE_CLK_HZ),
      .USE_ITER (USE_ITER_DIV)
   ) u_calc (
      .clk   (clk),
      .rst_n (rst_n),
      .start (calc_start),
      .idx   (calc_idx),
      .valid (calc_valid),
      .count (calc_count)
   );

   clkdiv_wait_timer #(.TW(TW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .value   (tmr_val),
      .expired (tmr_expired)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         cur_idx <= '0;
         tgt_idx <= '0;
         stp_idx <= '0;
         slow_q  <= 1'b0;
         new_cnt <= RC_RESET;
         mode_q  <= idx_to_mode(3'd0);
         rc_q    <= RC_RESET;
         sref_q  <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state)
            S_IDLE: begin
               if (req) begin
                  if (req_idx >= IDX_W'(NUM_RATIOS)) err_q <= 1'b1;
                  else if (req_idx == cur_idx)       done_q <= 1'b1;
                  else begin
                     tgt_idx <= req_idx;
                     stp_idx <= calc_idx;
                     state   <= S_CALC;
                  end
               end
            end
            S_CALC: begin
               if (calc_valid) begin
                  new_cnt <= calc_count;
                  slow_q  <= (stp_idx > cur_idx);
                  if (stp_idx > cur_idx)    state <= S_CNT;
                  else if (stp_idx == '0)   state <= S_SRCLR;
                  else                      state <= S_DIV;
               end
            end
            S_SRCLR: begin
               sref_q <= 1'b0;
               state  <= S_DIV;
            end
            S_CNT: begin
               rc_q <= new_cnt;
               if (!slow_q)      state <= S_NEXT;
               else if (!sref_q) state <= S_DRAIN;
               else              state <= S_DIV;
            end
            S_DRAIN: if (tmr_expired) state <= S_DIV;
            S_DIV: begin
               mode_q <= idx_to_mode(stp_idx);
               state  <= S_LOCK;
            end
            S_LOCK: begin
               if (tmr_expired) begin
                  if (!slow_q)              state <= S_CNT;
                  else if (cur_idx == '0)   state <= S_SRSET;
                  else                      state <= S_NEXT;
               end
            end
            S_SRSET: begin
               sref_q <= 1'b1;
               state  <= S_NEXT;
            end
            S_NEXT: begin
               cur_idx <= stp_idx;
               if (stp_idx == tgt_idx) begin
                  done_q <= 1'b1;
                  state  <= S_IDLE;
               end else begin
                  stp_idx <= calc_idx;
                  state   <= S_CALC;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign div_mode    = mode_q;
   assign refresh_cnt = rc_q;
   assign sref_en     = sref_q;
   assign busy        = (state != S_IDLE);
   assign done        = done_q;
   assign err         = err_q;

   // Settling-window tracker for the lock check.
   logic [MODE_W-1:0] seen_mode;
   logic [TW-1:0]     lock_age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_mode <= idx_to_mode(3'd0);
         lock_age  <= TW'(LOCK_CYCLES);
      end else begin
         seen_mode <= div_mode;
         if (div_mode != seen_mode)          lock_age <= '0;
         else if (lock_age < TW'(LOCK_CYCLES)) lock_age <= lock_age + 1'b1;
      end
   end

   assert_mode_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      div_mode inside {3'b000, 3'b001, 3'b011, 3'b010, 3'b100});
   assert_sref_off_at_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (div_mode == 3'b000) |-> !sref_en);
   assert_sref_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sref_en) |-> (div_mode == 3'b001));
   assert_leave_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(div_mode) == 3'b000 && div_mode != 3'b000) |-> (div_mode == 3'b001));
   assert_reach_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(div_mode) inside {3'b011, 3'b010, 3'b100}) |-> (div_mode != 3'b000));
   assert_lock_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_age < TW'(LOCK_CYCLES)) |-> ($stable(refresh_cnt) && $stable(sref_en) && !done));
   assert_err_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !done && $stable(div_mode)));
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/test_clkdiv_seq.sv
module test_clkdiv_seq;
   localparam longint unsigned HZ   = 64'd200_000_000;
   localparam int              LOCK = 16;
   localparam int EV_DIV = 0, EV_CNT = 1, EV_SRON = 2, EV_SROFF = 3;

   logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
   logic [2:0] req_idx = '0;
   logic [2:0] mode_a, mode_b;
   logic [6:0] rc_a, rc_b;
   logic sref_a, sref_b, busy_a, busy_b, done_a, done_b, err_a, err_b;

   always #4 clk = ~clk;

   clkdiv_seq #(.BASE_CLK_HZ(HZ), .LOCK_CYCLES(LOCK), .USE_ITER_DIV(1'b1)) i_clkdiv_seq (
      .clk(clk), .rst_n(rst_n), .req(req), .req_idx(req_idx),
      .div_mode(mode_a), .refresh_cnt(rc_a), .sref_en(sref_a),
      .busy(busy_a), .done(done_a), .err(err_a));

   clkdiv_seq #(.BASE_CLK_HZ(HZ), .LOCK_CYCLES(LOCK), .USE_ITER_DIV(1'b0)) i_clkdiv_seq_lut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_idx(req_idx),
      .div_mode(mode_b), .refresh_cnt(rc_b), .sref_en(sref_b),
      .busy(busy_b), .done(done_b), .err(err_b));

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   bit finished = 0;

   int ev_kind [64];
   int ev_cyc  [64];
   int ev_n = 0;
   int done_a_n = 0, done_b_n = 0, done_a_cyc = 0;
   int err_a_n = 0, err_b_n = 0, err_a_cyc = 0;
   bit busy_seen = 0;
   logic [2:0] pm; logic [6:0] pr; logic ps;

   int    exp_kind [16];
   int    exp_gap  [16];
   string exp_lbl  [16];
   int    exp_n = 0;
   int    cur_m = 0;
   bit    sref_m = 0;
   int    req_cyc = 0;

   function automatic int exp_ratio(input int idx);
      case (idx) 0: return 1; 1: return 2; 2: return 4; 3: return 6; default: return 8; endcase
   endfunction
   function automatic int exp_mode(input int idx);
      case (idx) 0: return 0; 1: return 1; 2: return 3; 3: return 2; default: return 4; endcase
   endfunction
   function automatic int exp_rc(input int idx);
      longint unsigned num = HZ * 64'd7800;
      return int'(num / (64'd64_000_000_000 * longint'(exp_ratio(idx))));
   endfunction

   task automatic report();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   task automatic check(input bit ok, input string rq, input longint act, input longint exv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exv);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         if (mode_a != pm) begin ev_kind[ev_n % 64] = EV_DIV; ev_cyc[ev_n % 64] = cyc; ev_n++; end
         if (rc_a != pr)   begin ev_kind[ev_n % 64] = EV_CNT; ev_cyc[ev_n % 64] = cyc; ev_n++; end
         if (sref_a != ps) begin
            ev_kind[ev_n % 64] = sref_a ? EV_SRON : EV_SROFF; ev_cyc[ev_n % 64] = cyc; ev_n++;
         end
         if (done_a) begin done_a_n++; done_a_cyc = cyc; end
         if (done_b) done_b_n++;
         if (err_a)  begin err_a_n++; err_a_cyc = cyc; end
         if (err_b)  err_b_n++;
         if (busy_a) busy_seen = 1;
      end
      pm = mode_a; pr = rc_a; ps = sref_a;
   end

   always @(posedge clk) begin
      if (cyc > 180000 && !finished) begin
         finished = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 180000);
         report();
         $finish;
      end
   end

   task automatic clear_obs();
      ev_n = 0; done_a_n = 0; done_b_n = 0; err_a_n = 0; err_b_n = 0; busy_seen = 0; exp_n = 0;
   endtask

   task automatic push(input int k, input int gap, input string lbl);
      if (exp_n > 0 && exp_kind[exp_n-1] == EV_DIV && gap < LOCK) gap = LOCK;
      exp_kind[exp_n] = k; exp_gap[exp_n] = gap; exp_lbl[exp_n] = lbl; exp_n++;
   endtask

   task automatic add_step(input int o, input int n, input string tag);
      if (n > o) begin
         push(EV_CNT, 0, tag);
         // R8: drain only when self-refresh is off
         push(EV_DIV, sref_m ? 0 : 64 * (exp_rc(n) + exp_rc(o)) * exp_ratio(o),
              sref_m ? tag : "R8");
         if (o == 0) begin push(EV_SRON, LOCK, "R4"); sref_m = 1; end
      end else begin
         if (n == 0) begin push(EV_SROFF, 0, "R3"); sref_m = 0; end
         push(EV_DIV, 0, tag);
         push(EV_CNT, LOCK, "R7");
      end
   endtask

   task automatic pulse(input int idx);
      @(negedge clk);
      req = 1'b1; req_idx = 3'(idx); req_cyc = cyc;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic run_req(input int idx, input int inject);
      string tag;
      clear_obs();
      if (idx == cur_m) begin
         pulse(idx);
         repeat (4) @(negedge clk);
         check(done_a_n == 1, "R9 done count", done_a_n, 1);
         check(done_a_cyc == req_cyc + 1, "R9 done latency", done_a_cyc - req_cyc, 1);
         check(ev_n == 0, "R9 outputs unchanged", ev_n, 0);
         check(!busy_seen, "R9 busy stays low", busy_seen, 0);
         return;
      end
      if ((cur_m == 0 && idx >= 2) || (cur_m >= 2 && idx == 0)) begin
         add_step(cur_m, 1, "R5");
         add_step(1, idx, "R5");
      end else begin
         if (cur_m == 1 && idx == 0)      tag = "R3";
         else if (cur_m == 0 && idx == 1) tag = "R4";
         else                             tag = "R6";
         add_step(cur_m, idx, tag);
      end
      pulse(idx);
      if (inject >= 0) begin
         repeat (30) @(negedge clk);
         check(busy_a == 1'b1, "R11 busy during transition", busy_a, 1);
         pulse(inject);
      end
      for (int k = 0; k < 30000 && !(done_a_n > 0 && done_b_n > 0); k++) @(negedge clk);
      check(done_a_n > 0 && done_b_n > 0, "R11 done reached", done_a_n, 1);
      repeat (60) @(negedge clk);
      check(done_a_n == 1, "R11 single done", done_a_n, 1);
      check(ev_n == exp_n, "R5 R6 event count", ev_n, exp_n);
      for (int i = 0; i < exp_n && i < ev_n; i++) begin
         check(ev_kind[i] == exp_kind[i], exp_lbl[i], ev_kind[i], exp_kind[i]);
         if (i > 0)
            check(ev_cyc[i] - ev_cyc[i-1] >= exp_gap[i], exp_lbl[i],
                  ev_cyc[i] - ev_cyc[i-1], exp_gap[i]);
      end
      if (ev_n > 0 && ev_n <= 64 && ev_kind[ev_n-1] == EV_DIV)
         check(done_a_cyc - ev_cyc[ev_n-1] >= LOCK, "R7 done after lock",
               done_a_cyc - ev_cyc[ev_n-1], LOCK);
      check(mode_a == 3'(exp_mode(idx)), "R1 mode", mode_a, exp_mode(idx));
      check(rc_a == 7'(exp_rc(idx)), "R2 refresh count", rc_a, exp_rc(idx));
      check(sref_a == (idx != 0), "R4 self-refresh", sref_a, idx != 0);
      check(busy_a == 1'b0, "R11 busy cleared", busy_a, 0);
      check(mode_b == mode_a && rc_b == rc_a && sref_b == sref_a, "R13 variants agree",
            {mode_b, rc_b, sref_b}, {mode_a, rc_a, sref_a});
      cur_m = idx;
   endtask

   task automatic run_bad(input int idx);
      clear_obs();
      pulse(idx);
      repeat (20) @(negedge clk);
      check(err_a_n == 1 && err_b_n == 1, "R10 err pulse", err_a_n, 1);
      check(err_a_cyc == req_cyc + 1, "R10 err latency", err_a_cyc - req_cyc, 1);
      check(ev_n == 0, "R10 outputs unchanged", ev_n, 0);
      check(done_a_n == 0, "R10 no done", done_a_n, 0);
   endtask

   initial begin
      int seed_dummy;
      int idx;
      seed_dummy = $urandom(32'h5EED_0C1C);
      repeat (3) @(negedge clk);
      check(mode_a == 3'b000, "R12 reset mode", mode_a, 0);
      check(rc_a == 7'(exp_rc(0)), "R12 reset count", rc_a, exp_rc(0));
      check(!sref_a && !busy_a && !done_a && !err_a, "R12 reset flags",
            {sref_a, busy_a, done_a, err_a}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_req(1, -1);  // R4
      run_req(0, -1);  // R3
      run_req(3, -1);  // R5
      run_req(2, -1);  // R6 speed up
      run_req(4, -1);  // R6 slow down
      run_req(0, -1);  // R5
      run_req(0, -1);  // R9
      run_bad(5);      // R10
      run_bad(7);
      run_req(4, 2);   // R11 ignored while busy
      run_req(4, -1);
      for (int r = 0; r < 14; r++) begin
         idx = int'($urandom_range(4, 0));
         run_req(idx, -1);
      end
      run_req(0, -1);
      finished = 1;
      report();
      $finish;
   end
endmodule